// File: doc/BRIEF.md
# Radio Power Mode Controller

This block chooses the operating mode of a radio transceiver and drives the power switches of an external RF front end. The inputs are a power-enable pin, a power-state field taken from a configuration register, a transmit/receive pin, a PA request pin, a band bit and a flag that is high while the receive DC-offset calibration runs. From these the block sets one of four modes: sleep, standby, idle or active. It then produces the switch drives for the front end and its two band power amplifiers, the band-select line, and enables for the internal TX path, RX path, synthesizers, crystal oscillator, reference clock buffer and serial port.

Every output comes from a register, so each one changes one clock after the inputs that cause it and carries no decode glitches. The front-end and PA switch drives are active low by default, because they gate P-channel switches. At most one PA is powered at a time, and only the PA of the selected band.

Top module: `rfmode_ctrl`

## Requirements
- R1: While `pwr_en` is low the block is in sleep whatever `pwr_state` holds. Every internal enable is 0, and `fe_sw`, `pa_a_sw` and `pa_b_sw` sit at their off level, which is 1 with the default polarity.
- R2: With `pwr_en` high, `pwr_state` selects the mode: 2'b11 is active, 2'b01 is idle, 2'b00 is standby, and the spare code 2'b10 also gives standby.
- R3: In standby `xo_en`, `refclk_en` and `serial_en` are 1. `synth_en`, `tx_en` and `rx_en` are 0, and the front end is off (`fe_sw` = 1).
- R4: Idle has the standby enables plus `synth_en` = 1. `tx_en` and `rx_en` stay 0 and the front end stays off.
- R5: Active mode has all standby and idle enables on. `tr_tx` = 1 gives `tx_en` = 1 and `rx_en` = 0. `tr_tx` = 0 gives `rx_en` = 1 and `tx_en` = 0. The front end is on (`fe_sw` = 0) unless calibration is running.
- R6: A PA drive goes to its on level (0) only in active mode with `pa_req` = 1, `tr_tx` = 1 and `cal_busy` = 0. `band_a` = 1 turns on `pa_a_sw` and `band_a` = 0 turns on `pa_b_sw`. The two drives are never on together.
- R7: `band_sel` equals `band_a` (1 = band A, 0 = band B) in every mode.
- R8: While `cal_busy` is 1, `fe_sw`, `pa_a_sw` and `pa_b_sw` are held off. The internal enables do not change.
- R9: All outputs are registered and show the inputs present at the previous rising clock edge. While `rst_n` is low, all enables and `band_sel` are 0 and the three switch drives are off (1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_en | input | 1 | Power enable pin; low forces sleep |
| pwr_state | input | 2 | Power-state field from the register (PS_W bits) |
| tr_tx | input | 1 | 1 = transmit, 0 = receive |
| pa_req | input | 1 | PA enable request |
| band_a | input | 1 | Band bit, 1 = band A, 0 = band B |
| cal_busy | input | 1 | High while the RX DC-offset calibration runs |
| fe_sw | output | 1 | Front-end power switch drive (0 = powered by default) |
| pa_a_sw | output | 1 | Band A PA switch drive (0 = powered by default) |
| pa_b_sw | output | 1 | Band B PA switch drive (0 = powered by default) |
| band_sel | output | 1 | Band-select line to the front end |
| tx_en | output | 1 | TX path enable |
| rx_en | output | 1 | RX path enable |
| synth_en | output | 1 | RF and IF oscillator/synthesizer enable |
| xo_en | output | 1 | Crystal oscillator enable |
| refclk_en | output | 1 | Reference clock buffer enable |
| serial_en | output | 1 | Serial port enable |

## Verification
The bench first applies all 128 combinations of the seven control inputs in counting order. This separates the sleep override from each power-state code, including the spare code, and shows whether each of TR, PA request, band and calibration acts on only the outputs it should. A long random run follows. In it, inputs flip on back-to-back cycles, which exposes a missing or extra register stage: the cycle-by-cycle model expects each output exactly one edge after its cause. It also exposes calibration that fails to override a PA that was already on.

// File: rtl/rfmode_pkg.sv
package rfmode_pkg;

   typedef enum logic [1:0] {
      MODE_SLEEP   = 2'd0,
      MODE_STANDBY = 2'd1,
      MODE_IDLE    = 2'd2,
      MODE_ACTIVE  = 2'd3
   } rf_mode_e;

   typedef struct packed {
      logic tx;
      logic rx;
      logic synth;
      logic xo;
      logic clk;
      logic ser;
   } path_en_t;

endpackage

// File: rtl/rfmode_decode.sv
module rfmode_decode
   import rfmode_pkg::*;
#(
   parameter int              PS_W        = 2,
   parameter logic [PS_W-1:0] CODE_ACTIVE = '1,
   parameter logic [PS_W-1:0] CODE_IDLE   = {{(PS_W-1){1'b0}}, 1'b1}
) (
   input  logic            pwr_en,
   input  logic [PS_W-1:0] ps,
   output rf_mode_e        mode
);

   generate
      if (CODE_ACTIVE == CODE_IDLE) begin : g_code_clash
         $error("rfmode_decode: active and idle codes must differ");
      end
   endgenerate

   // The pin overrides the register; any code other than the two named ones is standby.
   always_comb begin
      if (!pwr_en) begin
         mode = MODE_SLEEP;
      end else if (ps == CODE_ACTIVE) begin
         mode = MODE_ACTIVE;
      end else if (ps == CODE_IDLE) begin
         mode = MODE_IDLE;
      end else begin
         mode = MODE_STANDBY;
      end
   end

endmodule

// File: rtl/rfmode_enables.sv
module rfmode_enables
   import rfmode_pkg::*;
(
   input  rf_mode_e mode,
   input  logic     tr_tx,
   output path_en_t en
);

   logic awake;
   logic lo_on;
   logic live;

   assign awake = (mode != MODE_SLEEP);
   assign lo_on = (mode == MODE_IDLE) || (mode == MODE_ACTIVE);
   assign live  = (mode == MODE_ACTIVE);

   always_comb begin
      en.xo    = awake;
      en.clk   = awake;
      en.ser   = awake;
      en.synth = lo_on;
      en.tx    = live &&  tr_tx;
      en.rx    = live && !tr_tx;
   end

endmodule

// File: rtl/rfmode_fe_drive.sv
module rfmode_fe_drive
   import rfmode_pkg::*;
#(
   parameter  int N_BANDS = 2,
   localparam int BAND_W  = (N_BANDS > 1) ? $clog2(N_BANDS) : 1
) (
   input  rf_mode_e           mode,
   input  logic               tr_tx,
   input  logic               pa_req,
   input  logic [BAND_W-1:0]  band,
   input  logic               cal_busy,
   output logic               fe_on,
   output logic [N_BANDS-1:0] pa_on
);

   generate
      if (N_BANDS < 2) begin : g_band_count
         $error("rfmode_fe_drive: at least two bands are needed");
      end
   endgenerate

   logic pa_ok;

   // Calibration takes the whole front end down, the PAs included.
   assign fe_on = (mode == MODE_ACTIVE) && !cal_busy;
   assign pa_ok = fe_on && tr_tx && pa_req;

   generate
      for (genvar k = 0; k < N_BANDS; k++) begin : g_pa
         assign pa_on[k] = pa_ok && (band == BAND_W'(k));
      end
   endgenerate

endmodule

// File: rtl/rfmode_ctrl.sv
module rfmode_ctrl
   import rfmode_pkg::*;
#(
   parameter int PS_W          = 2,
   parameter bit FE_ACTIVE_LOW = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pwr_en,
   input  logic [PS_W-1:0] pwr_state,
   input  logic            tr_tx,
   input  logic            pa_req,
   input  logic            band_a,
   input  logic            cal_busy,
   output logic            fe_sw,
   output logic            pa_a_sw,
   output logic            pa_b_sw,
   output logic            band_sel,
   output logic            tx_en,
   output logic            rx_en,
   output logic            synth_en,
   output logic            xo_en,
   output logic            refclk_en,
   output logic            serial_en
);

   localparam int N_BANDS = 2;
   localparam int BAND_A  = 1;
   localparam int BAND_B  = 0;

   generate
      if (PS_W < 2) begin : g_ps_width
         $error("rfmode_ctrl: power-state field needs at least two bits");
      end
   endgenerate

   rf_mode_e           mode;
   path_en_t           en_d;
   path_en_t           en_q;
   logic               fe_on_d;
   logic               fe_on_q;
   logic [N_BANDS-1:0] pa_on_d;
   logic [N_BANDS-1:0] pa_on_q;
   logic               band_q;

   rfmode_decode #(
      .PS_W (PS_W)
   ) u_decode (
      .pwr_en (pwr_en),
      .ps     (pwr_state),
      .mode   (mode)
   );

   rfmode_enables u_enables (
      .mode  (mode),
      .tr_tx (tr_tx),
      .en    (en_d)
   );

   rfmode_fe_drive #(
      .N_BANDS (N_BANDS)
   ) u_fe_drive (
      .mode     (mode),
      .tr_tx    (tr_tx),
      .pa_req   (pa_req),
      .band     (band_a),
      .cal_busy (cal_busy),
      .fe_on    (fe_on_d),
      .pa_on    (pa_on_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         fe_on_q <= 1'b0;
         pa_on_q <= '0;
         band_q  <= 1'b0;
      end else begin
         en_q    <= en_d;
         fe_on_q <= fe_on_d;
         pa_on_q <= pa_on_d;
         band_q  <= band_a;
      end
   end

   assign tx_en     = en_q.tx;
   assign rx_en     = en_q.rx;
   assign synth_en  = en_q.synth;
   assign xo_en     = en_q.xo;
   assign refclk_en = en_q.clk;
   assign serial_en = en_q.ser;
   assign band_sel  = band_q;

   // The switch polarity is fixed at build time; only an inverter follows the flops.
   generate
      if (FE_ACTIVE_LOW) begin : g_drive_low
         assign fe_sw   = ~fe_on_q;
         assign pa_a_sw = ~pa_on_q[BAND_A];
         assign pa_b_sw = ~pa_on_q[BAND_B];
      end else begin : g_drive_high
         assign fe_sw   = fe_on_q;
         assign pa_a_sw = pa_on_q[BAND_A];
         assign pa_b_sw = pa_on_q[BAND_B];
      end
   endgenerate

endmodule

// File: rtl/rfmode_chk.sv
module rfmode_chk #(
   parameter int PS_W          = 2,
   parameter bit FE_ACTIVE_LOW = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            pwr_en,
   input logic [PS_W-1:0] pwr_state,
   input logic            tr_tx,
   input logic            pa_req,
   input logic            band_a,
   input logic            cal_busy,
   input logic            fe_sw,
   input logic            pa_a_sw,
   input logic            pa_b_sw,
   input logic            band_sel,
   input logic            tx_en,
   input logic            rx_en,
   input logic            synth_en,
   input logic            xo_en,
   input logic            refclk_en,
   input logic            serial_en
);

   logic fe_on;
   logic pa_a_on;
   logic pa_b_on;

   assign fe_on   = FE_ACTIVE_LOW ? ~fe_sw   : fe_sw;
   assign pa_a_on = FE_ACTIVE_LOW ? ~pa_a_sw : pa_a_sw;
   assign pa_b_on = FE_ACTIVE_LOW ? ~pa_b_sw : pa_b_sw;

   p_sleep_all_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |=> !(tx_en || rx_en || synth_en || xo_en || refclk_en || serial_en)
                  && !fe_on && !pa_a_on && !pa_b_on);

   p_spare_code_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en && pwr_state == PS_W'(2)) |=> xo_en && !synth_en && !tx_en && !rx_en);

   p_standby_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en && pwr_state == '0) |=> xo_en && refclk_en && serial_en
                                      && !synth_en && !tx_en && !rx_en && !fe_on);

   p_idle_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en && pwr_state == PS_W'(1)) |=> synth_en && xo_en && !tx_en && !rx_en && !fe_on);

   p_active_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en && pwr_state == '1) |=> synth_en && (tx_en == $past(tr_tx)) && (rx_en == !$past(tr_tx)));

   p_paths_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_en && rx_en));

   p_pa_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pa_a_on, pa_b_on}));

   p_pa_needs_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pa_a_on || pa_b_on) |-> tx_en && fe_on);

   p_pa_req_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pa_req |=> !pa_a_on && !pa_b_on);

   p_band_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_en || !pwr_en |=> band_sel == $past(band_a));

   p_cal_fe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cal_busy |=> !fe_on && !pa_a_on && !pa_b_on);

endmodule

bind rfmode_ctrl rfmode_chk #(
   .PS_W          (PS_W),
   .FE_ACTIVE_LOW (FE_ACTIVE_LOW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_en    (pwr_en),
   .pwr_state (pwr_state),
   .tr_tx     (tr_tx),
   .pa_req    (pa_req),
   .band_a    (band_a),
   .cal_busy  (cal_busy),
   .fe_sw     (fe_sw),
   .pa_a_sw   (pa_a_sw),
   .pa_b_sw   (pa_b_sw),
   .band_sel  (band_sel),
   .tx_en     (tx_en),
   .rx_en     (rx_en),
   .synth_en  (synth_en),
   .xo_en     (xo_en),
   .refclk_en (refclk_en),
   .serial_en (serial_en)
);

// File: tb/rfmode_ctrl_bench.sv
module rfmode_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       pwr_en;
   logic [1:0] pwr_state;
   logic       tr_tx;
   logic       pa_req;
   logic       band_a;
   logic       cal_busy;
   logic       fe_sw, pa_a_sw, pa_b_sw, band_sel;
   logic       tx_en, rx_en, synth_en, xo_en, refclk_en, serial_en;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   bit    e_tx, e_rx, e_syn, e_xo, e_clk, e_ser, e_fe, e_pa, e_pb, e_band;
   string e_tag;

   always #4 clk = ~clk;

   rfmode_ctrl u_rfmode_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_en    (pwr_en),
      .pwr_state (pwr_state),
      .tr_tx     (tr_tx),
      .pa_req    (pa_req),
      .band_a    (band_a),
      .cal_busy  (cal_busy),
      .fe_sw     (fe_sw),
      .pa_a_sw   (pa_a_sw),
      .pa_b_sw   (pa_b_sw),
      .band_sel  (band_sel),
      .tx_en     (tx_en),
      .rx_en     (rx_en),
      .synth_en  (synth_en),
      .xo_en     (xo_en),
      .refclk_en (refclk_en),
      .serial_en (serial_en)
   );

   task automatic chk(string tag, logic act, bit exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   // Expected outputs for the next edge, taken from the requirement text.
   task automatic predict();
      int m;   // 0 sleep, 1 standby, 2 idle, 3 active
      if (!pwr_en) begin
         m = 0; e_tag = "R1 sleep";
      end else begin
         case (pwr_state)
            2'b11:   begin m = 3; e_tag = "R5 active";  end
            2'b01:   begin m = 2; e_tag = "R4 idle";    end
            2'b10:   begin m = 1; e_tag = "R2 spare";   end
            default: begin m = 1; e_tag = "R3 standby"; end
         endcase
      end
      e_xo   = (m >= 1);
      e_clk  = (m >= 1);
      e_ser  = (m >= 1);
      e_syn  = (m >= 2);
      e_tx   = (m == 3) && tr_tx;
      e_rx   = (m == 3) && !tr_tx;
      e_fe   = (m == 3) && !cal_busy;
      e_pa   = e_fe && pa_req && tr_tx && band_a;
      e_pb   = e_fe && pa_req && tr_tx && !band_a;
      e_band = band_a;
   endtask

   task automatic compare();
      chk({e_tag, " xo_en"},           xo_en,     e_xo);
      chk({e_tag, " refclk_en"},       refclk_en, e_clk);
      chk({e_tag, " serial_en"},       serial_en, e_ser);
      chk({e_tag, " synth_en"},        synth_en,  e_syn);
      chk({e_tag, " tx_en"},           tx_en,     e_tx);
      chk({e_tag, " rx_en"},           rx_en,     e_rx);
      chk({e_tag, " R8 fe_sw"},        fe_sw,     !e_fe);
      chk({e_tag, " R6 pa_a_sw"},      pa_a_sw,   !e_pa);
      chk({e_tag, " R6 pa_b_sw"},      pa_b_sw,   !e_pb);
      chk({e_tag, " R7 band_sel"},     band_sel,  e_band);
   endtask

   task automatic check_reset();
      chk("R9 reset tx_en",     tx_en,     1'b0);
      chk("R9 reset rx_en",     rx_en,     1'b0);
      chk("R9 reset synth_en",  synth_en,  1'b0);
      chk("R9 reset xo_en",     xo_en,     1'b0);
      chk("R9 reset refclk_en", refclk_en, 1'b0);
      chk("R9 reset serial_en", serial_en, 1'b0);
      chk("R9 reset fe_sw",     fe_sw,     1'b1);
      chk("R9 reset pa_a_sw",   pa_a_sw,   1'b1);
      chk("R9 reset pa_b_sw",   pa_b_sw,   1'b1);
      chk("R9 reset band_sel",  band_sel,  1'b0);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      rst_n     = 1'b0;
      pwr_en    = 1'b1;
      pwr_state = 2'b11;
      tr_tx     = 1'b1;
      pa_req    = 1'b1;
      band_a    = 1'b1;
      cal_busy  = 1'b0;
      repeat (3) begin
         @(negedge clk);
         check_reset();
      end
      rst_n = 1'b1;
      predict();

      // Exhaustive sweep of all control combinations.
      for (int v = 0; v < 128; v++) begin
         @(negedge clk);
         compare();
         {pwr_en, pwr_state, tr_tx, pa_req, band_a, cal_busy} = 7'(v);
         predict();
      end

      // Random run: new inputs every cycle, mostly powered.
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         compare();
         pwr_en    = ($urandom_range(0, 7) != 0);
         pwr_state = 2'($urandom_range(0, 3));
         tr_tx     = 1'($urandom);
         pa_req    = ($urandom_range(0, 3) != 0);
         band_a    = 1'($urandom);
         cal_busy  = ($urandom_range(0, 4) == 0);
         predict();
      end

      @(negedge clk);
      compare();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R9 watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

endmodule